// File: doc/BRIEF.md
# SDRAM Start-up Command Sequencer

This block drives the command pins of a synchronous DRAM from reset until the memory is ready for ordinary traffic. After reset it holds the clock enable and the data mask high and keeps the bus at NOP for a fixed power-on interval. The interval is given in microseconds and converted to clock cycles from the clock frequency parameter. It then issues a precharge to every bank, a mode register load and a programmable number of auto refresh commands. Each command is followed by its own parameterized quiet interval.

Parameters set the CAS latency, burst length and burst ordering that go into the mode word. A parameter also chooses whether the mode register load comes before or after the refresh commands. Once the last quiet interval has run out, the ready flag rises and stays up until the next reset. From that cycle the data mask is released. All command pins come from registers, and the bus stays at NOP after start-up.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and from reset release until the first command, cke_o and dqm_o are 1 and the bus shows NOP (cs_n_o=0, ras_n_o=1, cas_n_o=1, we_n_o=1).
- R2: The first command other than NOP is visible after clock edge number CLK_MHZ*PWRUP_US, counting the first rising edge after reset release as edge 1.
- R3: The precharge-all command is cs_n_o=0, ras_n_o=0, cas_n_o=1, we_n_o=0, with addr_o bit 10 set and every other address bit 0.
- R4: The mode load command has all four command pins low. Its addr_o word is built as follows. Bits 2:0 hold the burst length code (1→000, 2→001, 4→010, 8→011, any other value→111). Bit 3 holds the burst order (0 sequential, 1 interleaved). Bits 6:4 hold the CAS latency. All higher bits are 0.
- R5: An auto refresh is cs_n_o=0, ras_n_o=0, cas_n_o=0, we_n_o=1, and exactly N_REF of them are issued.
- R6: With MRS_FIRST=1 the order is precharge, mode load, then the refreshes. With MRS_FIRST=0 the order is precharge, the refreshes, then mode load.
- R7: The next command follows exactly T_RP cycles after precharge, T_MRD cycles after mode load and T_RC cycles after each refresh, and the bus is NOP in between.
- R8: done_o rises at the edge where the last command's interval ends, so one command interval after the last command. The mode load has been issued once before it rises, and it stays high until reset.
- R9: While done_o is high, dqm_o is 0 and the bus is NOP.
- R10: Asserting rst_ni at any point, without a clock edge, forces done_o to 0, dqm_o to 1 and the bus to NOP, and the full sequence restarts from the power-on wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dqm_o | output | 1 | Data mask, high until start-up completes |
| ba_o | output | BAW | Bank select, held at 0 |
| addr_o | output | AW | Address bus: mode word or the all-banks bit |
| done_o | output | 1 | Start-up complete, sticky until reset |

## Verification
The end of one command's quiet interval and the issue of the next command land on the same clock edge. So do the end of the final interval and the rise of the ready flag. A second instance sets all intervals to one cycle and puts the refreshes first. Its commands then arrive back to back, and the refresh counter reaching its limit must hand over to the mode load in that same edge. The bench logs the cycle number of every command on both instances and compares it against a schedule computed from the parameters. Any lost or doubled cycle at a hand-over shows up as a wrong cycle or a wrong command count.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_MRS,
    CMD_REF
  } sdram_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_pins_t;

  function automatic sdram_pins_t cmd_pins(sdram_cmd_e c);
    sdram_pins_t p;
    unique case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

  // bits 2:0 burst length, 3 order, 6:4 latency, upper bits zero
  function automatic logic [11:0] mode_word(int unsigned cas, int unsigned bl, bit ilv);
    logic [2:0] blc;
    case (bl)
      1:       blc = 3'b000;
      2:       blc = 3'b001;
      4:       blc = 3'b010;
      8:       blc = 3'b011;
      default: blc = 3'b111;
    endcase
    return {5'b00000, 3'(cas), ilv, blc};
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CW = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CW'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R2, R7: interval counts down one per cycle
  a_r2_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  a_r7_timer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned N_REF = 8,
  parameter int unsigned T_RP = 3,
  parameter int unsigned T_RC = 7,
  parameter int unsigned T_MRD = 2,
  parameter bit MRS_FIRST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output sdram_cmd_e    cmd_o,
  output logic          done_o
);

  localparam int unsigned RW = $clog2(N_REF + 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);
  localparam logic [RW-1:0] REF_LAST = RW'(N_REF);

  typedef enum logic [2:0] {ST_WAIT, ST_PRE, ST_MRS, ST_REF, ST_DONE} state_e;

  state_e        state_q, state_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          done_q, done_d;

  always_comb begin
    state_d    = state_q;
    ref_d      = ref_q;
    done_d     = done_q;
    cmd_o      = CMD_NOP;
    load_o     = 1'b0;
    load_val_o = LD_RP;
    if (zero_i) begin
      unique case (state_q)
        ST_WAIT: begin
          cmd_o   = CMD_PRE;
          load_o  = 1'b1;
          state_d = ST_PRE;
        end
        ST_PRE: begin
          load_o = 1'b1;
          if (MRS_FIRST) begin
            cmd_o      = CMD_MRS;
            load_val_o = LD_MRD;
            state_d    = ST_MRS;
          end else begin
            cmd_o      = CMD_REF;
            load_val_o = LD_RC;
            ref_d      = ref_q + RW'(1);
            state_d    = ST_REF;
          end
        end
        ST_MRS: begin
          if (MRS_FIRST) begin
            cmd_o      = CMD_REF;
            load_o     = 1'b1;
            load_val_o = LD_RC;
            ref_d      = ref_q + RW'(1);
            state_d    = ST_REF;
          end else begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end
        end
        ST_REF: begin
          if (ref_q != REF_LAST) begin
            cmd_o      = CMD_REF;
            load_o     = 1'b1;
            load_val_o = LD_RC;
            ref_d      = ref_q + RW'(1);
          end else if (!MRS_FIRST) begin
            cmd_o      = CMD_MRS;
            load_o     = 1'b1;
            load_val_o = LD_MRD;
            state_d    = ST_MRS;
          end else begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      ref_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  a_r5_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= REF_LAST);

  a_r8_done_after_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ref_q == REF_LAST));

  a_r7_cmd_only_at_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> zero_i);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned BAW = 2,
  parameter logic [AW-1:0] MODE_OP = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  sdram_cmd_e     cmd_i,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o
);

  sdram_pins_t   pins_d, pins_q;
  logic [AW-1:0] addr_d, addr_q;

  always_comb begin
    pins_d = cmd_pins(cmd_i);
    addr_d = '0;
    unique case (cmd_i)
      CMD_PRE: addr_d[10] = 1'b1;
      CMD_MRS: addr_d     = MODE_OP;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= cmd_pins(CMD_NOP);
      addr_q <= '0;
    end else begin
      pins_q <= pins_d;
      addr_q <= addr_d;
    end
  end

  assign cs_n_o  = pins_q.cs_n;
  assign ras_n_o = pins_q.ras_n;
  assign cas_n_o = pins_q.cas_n;
  assign we_n_o  = pins_q.we_n;
  assign addr_o  = addr_q;
  assign ba_o    = '0;

  // R3: precharge always targets every bank
  a_r3_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[10]);

  // R4: mode load carries the opcode
  a_r4_mode_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && !cas_n_o && !we_n_o) |-> (addr_o == MODE_OP));

  // R7: each command lasts one cycle
  a_r7_single_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> ($past(cmd_i) != CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned PWRUP_US = 200,
  parameter int unsigned T_RP = 3,
  parameter int unsigned T_RC = 7,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned N_REF = 8,
  parameter int unsigned CAS_LAT = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter bit BURST_ILV = 1'b0,
  parameter bit MRS_FIRST = 1'b1,
  parameter int unsigned AW = 12,
  parameter int unsigned BAW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic           dqm_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           done_o
);

  localparam int unsigned PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int unsigned T_MAX0  = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int unsigned T_MAX1  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
  localparam int unsigned T_MAX   = (T_MAX1 > PWR_CYC) ? T_MAX1 : PWR_CYC;
  localparam int unsigned CW      = $clog2(T_MAX + 1);
  localparam logic [AW-1:0] MODE_OP = AW'(mode_word(CAS_LAT, BURST_LEN, BURST_ILV));

  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  sdram_cmd_e    cmd;

  sdram_init_timer #(.CW(CW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_fsm #(
    .CW(CW), .N_REF(N_REF), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .MRS_FIRST(MRS_FIRST)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (tmr_zero),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .cmd_o      (cmd),
    .done_o     (done_o)
  );

  sdram_init_cmd_enc #(.AW(AW), .BAW(BAW), .MODE_OP(MODE_OP)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign cke_o = 1'b1;
  assign dqm_o = ~done_o;

  // R7: a running interval yields a NOP on the next bus cycle
  a_r7_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_zero |=> (ras_n_o && cas_n_o && we_n_o));

  // R9: nothing issued once ready
  a_r9_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (ras_n_o && cas_n_o && we_n_o && !dqm_o));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  // main instance: defaults
  localparam int M_PWR = 100 * 200;
  // alternate instance: refresh first, one-cycle gaps
  localparam int A_PWR = 1 * 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_cke, m_cs, m_ras, m_cas, m_we, m_dqm, m_done;
  logic [1:0] m_ba;
  logic [11:0] m_addr;
  logic a_cke, a_cs, a_ras, a_cas, a_we, a_dqm, a_done;
  logic [1:0] a_ba;
  logic [11:0] a_addr;

  sdram_init_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(m_cke), .cs_n_o(m_cs), .ras_n_o(m_ras),
    .cas_n_o(m_cas), .we_n_o(m_we), .dqm_o(m_dqm), .ba_o(m_ba), .addr_o(m_addr),
    .done_o(m_done)
  );

  sdram_init_seq #(
    .CLK_MHZ(1), .PWRUP_US(200), .T_RP(1), .T_RC(1), .T_MRD(1), .N_REF(8),
    .CAS_LAT(2), .BURST_LEN(8), .BURST_ILV(1'b1), .MRS_FIRST(1'b0)
  ) dut_alt_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras),
    .cas_n_o(a_cas), .we_n_o(a_we), .dqm_o(a_dqm), .ba_o(a_ba), .addr_o(a_addr),
    .done_o(a_done)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // command kinds: 0 NOP, 1 PRE, 2 MRS, 3 REF, 9 illegal
  function automatic int dec(logic cs, logic ras, logic cas, logic we);
    if (cs) return 0;
    case ({ras, cas, we})
      3'b111: return 0;
      3'b010: return 1;
      3'b000: return 2;
      3'b001: return 3;
      default: return 9;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitors
  int m_n, m_ill, m_waitv, m_postv, m_drop, m_done_cyc;
  int m_kind[32], m_cyc[32], m_adr[32];
  logic m_prev;
  int a_n, a_ill, a_waitv, a_postv, a_drop, a_done_cyc;
  int a_kind[32], a_cyc[32], a_adr[32];
  logic a_prev;

  task automatic clear_logs();
    m_n = 0; m_ill = 0; m_waitv = 0; m_postv = 0; m_drop = 0; m_done_cyc = -1; m_prev = 1'b0;
    a_n = 0; a_ill = 0; a_waitv = 0; a_postv = 0; a_drop = 0; a_done_cyc = -1; a_prev = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int k = dec(m_cs, m_ras, m_cas, m_we);
      if (k == 9) m_ill++;
      if (m_n == 0 && k == 0 && (!m_cke || !m_dqm || m_cs)) m_waitv++;
      if (k != 0 && m_n < 32) begin
        m_kind[m_n] = k; m_cyc[m_n] = cyc; m_adr[m_n] = int'(m_addr); m_n++;
      end
      if (m_done && (m_dqm || k != 0)) m_postv++;
      if (m_prev && !m_done) m_drop++;
      if (m_done && m_done_cyc < 0) m_done_cyc = cyc;
      m_prev = m_done;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int k = dec(a_cs, a_ras, a_cas, a_we);
      if (k == 9) a_ill++;
      if (a_n == 0 && k == 0 && (!a_cke || !a_dqm || a_cs)) a_waitv++;
      if (k != 0 && a_n < 32) begin
        a_kind[a_n] = k; a_cyc[a_n] = cyc; a_adr[a_n] = int'(a_addr); a_n++;
      end
      if (a_done && (a_dqm || k != 0)) a_postv++;
      if (a_prev && !a_done) a_drop++;
      if (a_done && a_done_cyc < 0) a_done_cyc = cyc;
      a_prev = a_done;
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check_reset_state();
    chk(m_cke && m_dqm && !m_done, "R1 main cke/dqm/done in reset", {m_cke, m_dqm, m_done}, 3'b110);
    chk(dec(m_cs, m_ras, m_cas, m_we) == 0 && !m_cs, "R1 main NOP in reset", {m_cs, m_ras, m_cas, m_we}, 4'b0111);
    chk(a_cke && a_dqm && !a_done, "R1 alt cke/dqm/done in reset", {a_cke, a_dqm, a_done}, 3'b110);
    chk(dec(a_cs, a_ras, a_cas, a_we) == 0 && !a_cs, "R1 alt NOP in reset", {a_cs, a_ras, a_cas, a_we}, 4'b0111);
  endtask

  task automatic check_midway_reset();
    while (cyc < M_PWR + 30) @(negedge clk);
    chk(m_n >= 3 && !m_done, "R10 main mid-sequence before reset", m_n, 3);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(!m_done && m_dqm, "R10 main done/dqm async", {m_done, m_dqm}, 2'b01);
    chk({m_cs, m_ras, m_cas, m_we} == 4'b0111, "R10 main NOP async", {m_cs, m_ras, m_cas, m_we}, 4'b0111);
    chk(!a_done && a_dqm, "R10 alt done/dqm async", {a_done, a_dqm}, 2'b01);
    repeat (2) @(negedge clk);
    clear_logs();
    rst_n = 1'b1;
  endtask

  task automatic run_main();
    int exp_c;
    while (m_done_cyc < 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(m_waitv == 0, "R1 main NOP/cke/dqm during wait", m_waitv, 0);
    chk(m_ill == 0, "R7 main no illegal pins", m_ill, 0);
    chk(m_n == 10, "R5 main command count", m_n, 10);
    chk(m_kind[0] == 1, "R6 main first is precharge", m_kind[0], 1);
    chk(m_cyc[0] == M_PWR, "R2 main precharge cycle", m_cyc[0], M_PWR);
    chk(m_adr[0] == 'h400, "R3 main precharge address", m_adr[0], 'h400);
    chk(m_kind[1] == 2, "R6 main mode load second", m_kind[1], 2);
    chk(m_cyc[1] == M_PWR + 3, "R7 main tRP gap", m_cyc[1], M_PWR + 3);
    chk(m_adr[1] == 'h032, "R4 main mode word", m_adr[1], 'h032);
    for (int i = 2; i < 10; i++) begin
      exp_c = M_PWR + 5 + 7 * (i - 2);
      chk(m_kind[i] == 3, "R5 main refresh kind", m_kind[i], 3);
      chk(m_cyc[i] == exp_c, "R7 main refresh cycle", m_cyc[i], exp_c);
    end
    chk(m_done_cyc == M_PWR + 61, "R8 main done cycle", m_done_cyc, M_PWR + 61);
  endtask

  task automatic run_alt();
    chk(a_waitv == 0, "R1 alt NOP/cke/dqm during wait", a_waitv, 0);
    chk(a_ill == 0, "R7 alt no illegal pins", a_ill, 0);
    chk(a_n == 10, "R5 alt command count", a_n, 10);
    chk(a_kind[0] == 1 && a_cyc[0] == A_PWR, "R2 alt precharge cycle", a_cyc[0], A_PWR);
    chk(a_adr[0] == 'h400, "R3 alt precharge address", a_adr[0], 'h400);
    for (int i = 1; i < 9; i++) begin
      chk(a_kind[i] == 3, "R6 alt refresh before mode load", a_kind[i], 3);
      chk(a_cyc[i] == A_PWR + i, "R7 alt back-to-back refresh", a_cyc[i], A_PWR + i);
    end
    chk(a_kind[9] == 2 && a_cyc[9] == A_PWR + 9, "R6 alt mode load last", a_cyc[9], A_PWR + 9);
    chk(a_adr[9] == 'h02B, "R4 alt mode word", a_adr[9], 'h02B);
    chk(a_done_cyc == A_PWR + 10, "R8 alt done cycle", a_done_cyc, A_PWR + 10);
  endtask

  task automatic check_hold();
    repeat (50) @(negedge clk);
    chk(m_done && a_done, "R8 done held", {m_done, a_done}, 2'b11);
    chk(m_drop == 0 && a_drop == 0, "R8 done never drops", m_drop + a_drop, 0);
    chk(m_postv == 0, "R9 main quiet and dqm low after done", m_postv, 0);
    chk(a_postv == 0, "R9 alt quiet and dqm low after done", a_postv, 0);
    chk(m_n == 10 && a_n == 10, "R9 no commands after done", m_n + a_n, 20);
  endtask

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    check_midway_reset();
    run_main();
    run_alt();
    check_hold();
    report();
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
    report();
  end

endmodule